// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two up-counting timer/counters, unit 0 and unit 1. Each unit has a low count byte, a high count byte, a run bit and a sticky overflow flag. One shared 8-bit configuration byte picks, for each unit, where its ticks come from and how it counts. A tick is either an internal machine-cycle strobe, which fires once every `TICK_DIV` clocks, or a falling edge seen on that unit's external pin.

There are four counting modes. The first is a 13-bit count in which the low five bits act as a prescaler feeding the high byte. The second is a plain 16-bit count. The third is an 8-bit count that reloads its low byte from the high byte. The last is a split mode in which unit 0 becomes two independent 8-bit counters, and the upper one takes over unit 1's run and flag bits.

Software drives a single write port. Each write carries a 3-bit target select and a data byte, and it takes effect at the next rising clock edge. The two 16-bit counts and the two flags are visible as outputs at all times.

Top module: `tmr_pair`

## Requirements
- R1: Synchronous active-low reset clears both count words, both flags, both run bits and the configuration byte.
- R2: When a unit's tick-source bit (bit 2 of its nibble) is 0, it advances once per machine-cycle strobe, while its run bit is 1. After reset is released, the strobe first fires on the 12th rising edge and then on every 12th rising edge after that (`TICK_DIV` = 12).
- R3: When the tick-source bit is 1, the unit advances once per falling edge of its external pin. The pin passes through two synchroniser flops, and the synchronised level is sampled only on machine-cycle strobes. A tick occurs on a strobe whose sample is 0 when the previous strobe's sample was 1.
- R4: Mode 00 (13-bit) counts in low bits 4:0. When they wrap from 1Fh, they carry into the high byte. The flag sets when the whole 13-bit value wraps to zero. Low bits 7:5 never change while counting.
- R5: Mode 01 (16-bit) increments {high, low}. The flag sets on the step from FFFFh to 0000h.
- R6: Mode 10 (auto-reload) counts only the low byte. On a step from FFh, the low byte takes the high byte's value and the flag sets. A write to the high byte while the unit is in mode 10 and its run bit is 0 also loads the low byte.
- R7: Mode 11 on unit 0 (split) makes low byte 0 count unit 0's ticks under run bit 0, setting flag 0 when it wraps from FFh to 00h. High byte 0 counts machine-cycle strobes under run bit 1, setting flag 1 when it wraps from FFh to 00h.
- R8: While unit 0 is split, unit 1 in modes 00 to 10 counts its ticks regardless of run bit 1 and never sets flag 1. Unit 1 in mode 11 holds its count.
- R9: A unit whose run bit is 0 holds its count, except for writes.
- R10: A flag stays set until a flag-clear write with a 1 in that flag's bit position. If a set and a clear happen in the same cycle, the set wins.
- R11: The write select codes are 0 for configuration, 1 for unit 0 low, 2 for unit 0 high, 3 for unit 1 low, 4 for unit 1 high, 5 for the run bits (data bit i to unit i), 6 for flag clear (data bit i clears flag i) and 7 for no target. A write to either count byte of a unit suspends that unit's counting in that cycle, including both halves in split mode.
- R12: In the configuration byte, bits 3:0 belong to unit 0 and bits 7:4 to unit 1. Within each nibble, bits 1:0 are the mode, bit 2 is the tick source, and bit 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| ext_pin | input | 2 | External tick pins, bit i for unit i |
| cnt0 | output | 16 | Unit 0 count {high, low} |
| cnt1 | output | 16 | Unit 1 count {high, low} |
| ovf_flag | output | 2 | Sticky overflow flags, bit i for unit i |

## Verification
Directed sequences start each mode from a preload just below its wrap point. These tell apart the 13-bit, 16-bit, reload and split roll-over rules, and they show which flag each half of a split unit sets.

Pin pulses that are wider than a machine cycle separate edge counting from level counting. A stopped timer 1 under split mode shows whether the run bit is ignored.

A long seeded random phase then mixes configuration, run, flag-clear and count-byte writes with random pin levels. It is compared every cycle against a cycle-level model built from the requirements. This exposes the cases where two things happen in the same cycle: a write while counting, a flag set while it is being cleared, and a mode change while a count is under way.

// File: rtl/tmr_pkg.sv
// Shared types for the dual timer/counter: counting modes and write targets.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_13     = 2'b00,
        MODE_16     = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    typedef enum logic [2:0] {
        SEL_CFG  = 3'd0,
        SEL_T0LO = 3'd1,
        SEL_T0HI = 3'd2,
        SEL_T1LO = 3'd3,
        SEL_T1HI = 3'd4,
        SEL_RUN  = 3'd5,
        SEL_FCLR = 3'd6,
        SEL_NONE = 3'd7
    } wr_sel_e;
endpackage

// File: rtl/tmr_tick.sv
// Machine-cycle strobe generator: one-clock pulse every TICK_DIV clocks.
// Assumes TICK_DIV >= 2. Counter restarts from zero on reset.
module tmr_tick #(
    parameter int TICK_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(TICK_DIV);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_edge.sv
// External pin falling-edge detector: two-flop synchroniser, then the
// synchronised level is sampled once per machine-cycle strobe.
// Assumes pin pulses last longer than one machine cycle to be seen.
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic s1_q, s2_q, smp_q;

    assign fall = tick & smp_q & ~s2_q;

    // Synchronise the pin and hold the last strobe-time sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            smp_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            if (tick) smp_q <= s2_q;
        end
    end

    assert_fall_resample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !smp_q);
endmodule

// File: rtl/tmr_unit.sv
// One timer's count bytes and roll-over rules for the four modes.
// adv advances the main count; adv_hi advances the high byte in split mode.
// A write to either byte suspends counting that cycle. ovf/ovf_hi are
// single-cycle wrap pulses. Assumes wr_lo and wr_hi are never both high.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int LOW_PRE = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_e mode,
    input  logic      adv,
    input  logic      adv_hi,
    input  logic      wr_lo,
    input  logic      wr_hi,
    input  logic      running,
    input  logic [7:0] wr_data,
    output logic [7:0] lo_q,
    output logic [7:0] hi_q,
    output logic      ovf,
    output logic      ovf_hi
);
    localparam logic [LOW_PRE-1:0] PRE_MAX = '1;

    logic [7:0] lo_n, hi_n;

    // Next-count selection: writes first, otherwise mode-specific stepping.
    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        if (wr_lo || wr_hi) begin
            if (wr_lo) lo_n = wr_data;
            if (wr_hi) begin
                hi_n = wr_data;
                if (mode == MODE_RELOAD && !running) lo_n = wr_data;
            end
        end else begin
            unique case (mode)
                MODE_13: if (adv) begin
                    if (lo_q[LOW_PRE-1:0] == PRE_MAX) begin
                        lo_n[LOW_PRE-1:0] = '0;
                        hi_n = hi_q + 8'd1;
                        ovf  = (hi_q == 8'hFF);
                    end else begin
                        lo_n[LOW_PRE-1:0] = lo_q[LOW_PRE-1:0] + LOW_PRE'(1);
                    end
                end
                MODE_16: if (adv) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + 16'd1;
                    ovf = &{hi_q, lo_q};
                end
                MODE_RELOAD: if (adv) begin
                    if (lo_q == 8'hFF) begin
                        lo_n = hi_q;
                        ovf  = 1'b1;
                    end else begin
                        lo_n = lo_q + 8'd1;
                    end
                end
                MODE_SPLIT: begin
                    if (adv) begin
                        lo_n = lo_q + 8'd1;
                        ovf  = (lo_q == 8'hFF);
                    end
                    if (adv_hi) begin
                        hi_n   = hi_q + 8'd1;
                        ovf_hi = (hi_q == 8'hFF);
                    end
                end
            endcase
        end
    end

    // Count byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !adv_hi && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    assert_wrap16_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_16 && adv && !wr_lo && !wr_hi && {hi_q, lo_q} == 16'hFFFF)
        |=> ({hi_q, lo_q} == 16'h0000));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RELOAD && adv && !wr_lo && !wr_hi && lo_q == 8'hFF)
        |=> (lo_q == $past(hi_q)));

    assert_pre_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_13 && !wr_lo && !wr_hi)
        |=> (lo_q[7:LOW_PRE] == $past(lo_q[7:LOW_PRE])));
endmodule

// File: rtl/tmr_pair.sv
// Dual timer/counter top: configuration, run and flag registers, tick
// source selection and split-mode routing of run/flag bits. Write port
// decoding follows the select codes in tmr_pkg. Gate bits are ignored.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int TICK_DIV = 12,
    parameter int LOW_PRE  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  ext_pin,
    output logic [15:0] cnt0,
    output logic [15:0] cnt1,
    output logic [1:0]  ovf_flag
);
    localparam int NUM_T = 2;

    wr_sel_e    sel;
    logic       mtick;
    logic       split;
    logic [2:0] cfg_q [NUM_T];
    tmr_mode_e  mode  [NUM_T];
    logic [1:0] run_q, flag_q, flag_set, flag_clr;
    logic [1:0] fall, tick, adv, adv_h, wlo, whi, ovf_lo, ovf_h;
    logic [7:0] lo_q  [NUM_T];
    logic [7:0] hi_q  [NUM_T];

    assign sel = wr_en ? wr_sel_e'(wr_sel) : SEL_NONE;

    tmr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(mtick)
    );

    generate
        for (genvar g = 0; g < NUM_T; g++) begin : g_tmr
            tmr_edge u_edge (
                .clk(clk), .rst_n(rst_n), .tick(mtick),
                .pin(ext_pin[g]), .fall(fall[g])
            );

            assign mode[g] = tmr_mode_e'(cfg_q[g][1:0]);
            assign tick[g] = cfg_q[g][2] ? fall[g] : mtick;

            tmr_unit #(.LOW_PRE(LOW_PRE)) u_unit (
                .clk(clk), .rst_n(rst_n), .mode(mode[g]),
                .adv(adv[g]), .adv_hi(adv_h[g]),
                .wr_lo(wlo[g]), .wr_hi(whi[g]), .running(run_q[g]),
                .wr_data(wr_data), .lo_q(lo_q[g]), .hi_q(hi_q[g]),
                .ovf(ovf_lo[g]), .ovf_hi(ovf_h[g])
            );

            assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[g] && !(sel == SEL_FCLR && wr_data[g])) |=> flag_q[g]);
        end
    endgenerate

    assign split    = (mode[0] == MODE_SPLIT);
    assign wlo      = {sel == SEL_T1LO, sel == SEL_T0LO};
    assign whi      = {sel == SEL_T1HI, sel == SEL_T0HI};
    assign adv[0]   = tick[0] & run_q[0];
    assign adv_h[0] = mtick & run_q[1];
    assign adv[1]   = (mode[1] != MODE_SPLIT) & tick[1] & (split | run_q[1]);
    assign adv_h[1] = 1'b0;

    assign flag_set[0] = ovf_lo[0];
    assign flag_set[1] = split ? ovf_h[0] : (ovf_lo[1] | ovf_h[1]);
    assign flag_clr    = (sel == SEL_FCLR) ? wr_data[1:0] : 2'b00;

    // Configuration, run and sticky flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q[0] <= '0;
            cfg_q[1] <= '0;
            run_q    <= '0;
            flag_q   <= '0;
        end else begin
            if (sel == SEL_CFG) begin
                cfg_q[0] <= wr_data[2:0];
                cfg_q[1] <= wr_data[6:4];
            end
            if (sel == SEL_RUN) run_q <= wr_data[1:0];
            flag_q <= flag_set | (flag_q & ~flag_clr);
        end
    end

    assign cnt0     = {hi_q[0], lo_q[0]};
    assign cnt1     = {hi_q[1], lo_q[1]};
    assign ovf_flag = flag_q;

    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && !run_q[0] && !wlo[0] && !whi[0]) |=> $stable(cnt0));

    assert_t1_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (split && mode[1] == MODE_16 && !cfg_q[1][2] && mtick && !wlo[1] && !whi[1])
        |=> (cnt1 != $past(cnt1)));
endmodule

// File: tb/test_tmr_pair.sv
// Self-checking bench: directed mode scenarios plus seeded random traffic,
// compared each cycle against a cycle-level model written from the brief.
module test_tmr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7;
    logic [7:0]  wr_data = 8'd0;
    logic [1:0]  ext_pin = 2'b00;
    logic [15:0] cnt0, cnt1;
    logic [1:0]  ovf_flag;

    always #10 clk = ~clk;

    tmr_pair i_tmr_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_pin(ext_pin),
        .cnt0(cnt0), .cnt1(cnt1), .ovf_flag(ovf_flag)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [2:0] m_cfg [2];
    logic [1:0] m_run, m_flag, m_s1, m_s2, m_smp, e, fs, fc;
    int         m_pc;
    logic       mt, sp, tk0, tk1, a0, a0h, a1, o0, o0h, o1, o1h;
    logic [2:0] w;

    task automatic bump(input logic [1:0] md, input logic a, input logic ah,
                        inout logic [7:0] lo, inout logic [7:0] hi,
                        output logic o, output logic oh);
        o = 1'b0;
        oh = 1'b0;
        case (md)
            2'd0: if (a) begin
                if (lo[4:0] == 5'h1F) begin
                    lo[4:0] = 5'h00;
                    o = (hi == 8'hFF);
                    hi = hi + 8'd1;
                end else lo[4:0] = lo[4:0] + 5'd1;
            end
            2'd1: if (a) begin
                o = ({hi, lo} == 16'hFFFF);
                {hi, lo} = {hi, lo} + 16'd1;
            end
            2'd2: if (a) begin
                if (lo == 8'hFF) begin
                    lo = hi;
                    o = 1'b1;
                end else lo = lo + 8'd1;
            end
            default: begin
                if (a) begin
                    o = (lo == 8'hFF);
                    lo = lo + 8'd1;
                end
                if (ah) begin
                    oh = (hi == 8'hFF);
                    hi = hi + 8'd1;
                end
            end
        endcase
    endtask

    // Model step on each rising edge, reading inputs driven at falling edges.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_lo[i] = 8'd0; m_hi[i] = 8'd0; m_cfg[i] = 3'd0;
            end
            m_run = 2'b00; m_flag = 2'b00; m_pc = 0;
            m_s1 = 2'b00; m_s2 = 2'b00; m_smp = 2'b00;
        end else begin
            mt = (m_pc == 11);
            for (int i = 0; i < 2; i++) begin
                e[i] = mt && m_smp[i] && !m_s2[i];
                if (mt) m_smp[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = ext_pin[i];
            end
            m_pc = mt ? 0 : m_pc + 1;
            w   = wr_en ? wr_sel : 3'd7;
            sp  = (m_cfg[0][1:0] == 2'd3);
            tk0 = m_cfg[0][2] ? e[0] : mt;
            tk1 = m_cfg[1][2] ? e[1] : mt;
            a0  = tk0 && m_run[0];
            a0h = mt && m_run[1];
            a1  = (m_cfg[1][1:0] != 2'd3) && tk1 && (sp || m_run[1]);
            o0 = 1'b0; o0h = 1'b0; o1 = 1'b0; o1h = 1'b0;
            if (w == 3'd1) m_lo[0] = wr_data;
            else if (w == 3'd2) begin
                m_hi[0] = wr_data;
                if (m_cfg[0][1:0] == 2'd2 && !m_run[0]) m_lo[0] = wr_data;
            end else bump(m_cfg[0][1:0], a0, a0h, m_lo[0], m_hi[0], o0, o0h);
            if (w == 3'd3) m_lo[1] = wr_data;
            else if (w == 3'd4) begin
                m_hi[1] = wr_data;
                if (m_cfg[1][1:0] == 2'd2 && !m_run[1]) m_lo[1] = wr_data;
            end else bump(m_cfg[1][1:0], a1, 1'b0, m_lo[1], m_hi[1], o1, o1h);
            fs[0] = o0;
            fs[1] = sp ? o0h : o1;
            fc = (w == 3'd6) ? wr_data[1:0] : 2'b00;
            m_flag = fs | (m_flag & ~fc);
            if (w == 3'd5) m_run = wr_data[1:0];
            if (w == 3'd0) begin
                m_cfg[0] = wr_data[2:0];
                m_cfg[1] = wr_data[6:4];
            end
        end
    end

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            check("cnt0", cnt0, {m_hi[0], m_lo[0]});
            check("cnt1", cnt1, {m_hi[1], m_lo[1]});
            check("flags", {14'd0, ovf_flag}, {14'd0, m_flag});
        end
    end

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 3'd7;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [1:0] pins);
        @(negedge clk);
        ext_pin = pins;
        idle(30);
        ext_pin = 2'b00;
        idle(30);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R5: 16-bit roll-over from FFF2h on unit 0.
        cur_req = "R5";
        wr(3'd0, 8'h01); wr(3'd1, 8'hF2); wr(3'd2, 8'hFF); wr(3'd5, 8'h01);
        idle(12 * 20);
        // R10: clear flag 0 while still counting.
        cur_req = "R10";
        wr(3'd6, 8'h01); idle(24); wr(3'd5, 8'h00);
        // R2: unit 1 on machine-cycle ticks.
        cur_req = "R2";
        wr(3'd0, 8'h10); wr(3'd3, 8'hFC); wr(3'd4, 8'hFF); wr(3'd5, 8'h02);
        idle(12 * 8);
        // R4: 13-bit count near its wrap.
        cur_req = "R4";
        wr(3'd5, 8'h00); wr(3'd6, 8'h03); wr(3'd0, 8'h00);
        wr(3'd1, 8'hFC); wr(3'd2, 8'hFF); wr(3'd5, 8'h01);
        idle(12 * 10);
        // R6: reload with copy of the high byte while stopped.
        cur_req = "R6";
        wr(3'd5, 8'h00); wr(3'd6, 8'h03); wr(3'd0, 8'h02); wr(3'd2, 8'hFC);
        wr(3'd5, 8'h01); idle(12 * 12);
        // R3: external pin edges on both units.
        cur_req = "R3";
        wr(3'd5, 8'h00); wr(3'd0, 8'h65); wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFD); wr(3'd4, 8'hFD); wr(3'd5, 8'h03);
        for (int k = 0; k < 4; k++) pulse(2'b11);
        pulse(2'b01);
        // R7: split mode, both halves and their flags.
        cur_req = "R7";
        wr(3'd5, 8'h00); wr(3'd0, 8'h03); wr(3'd1, 8'hFD); wr(3'd2, 8'hFE);
        wr(3'd6, 8'h03); wr(3'd5, 8'h03); idle(12 * 6);
        wr(3'd5, 8'h02); idle(12 * 4);
        // R8: unit 1 free-running under split, then held in mode 11.
        cur_req = "R8";
        wr(3'd5, 8'h00); wr(3'd0, 8'h13); wr(3'd3, 8'hFE); wr(3'd4, 8'hFF);
        idle(12 * 5); wr(3'd0, 8'h33); idle(12 * 3);
        // R9: stopped units hold.
        cur_req = "R9";
        wr(3'd0, 8'h11); wr(3'd5, 8'h00); idle(12 * 4);
        // R11: count writes while running.
        cur_req = "R11";
        wr(3'd5, 8'h03);
        for (int k = 0; k < 20; k++) begin
            wr(3'($urandom_range(1, 4)), 8'($urandom_range(240, 255)));
            idle($urandom_range(0, 14));
        end
        // R12: random configuration, pins and writes, gate bits included.
        cur_req = "R12";
        for (int k = 0; k < 400; k++) begin
            ext_pin = 2'($urandom_range(0, 3));
            wr(3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)));
            idle($urandom_range(0, 30));
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule